// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between the register interface of an SPI peripheral and its serial shifter. It holds a transmit queue, which software fills through a data register and the shifter drains through a pop port, and a receive queue, which the shifter fills through a push port and software drains by reading the same data register. The block derives every flag that depends on how full those queues are: the status word, the interrupt vector with its mask and sticky error flags, and the two DMA request lines.

Software reaches the block through a flat register port. A write strobe, a read strobe, a 4-bit address and a data word select and carry the access. Read data is combinational from the addressed register. A read of the data register removes the head of the receive queue in the cycle of the read strobe. Each threshold and DMA level register refuses values at or above the queue depth. Software can therefore probe the depth by writing a value and reading it back.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: After reset, both queue levels are 0, the status word is 0x0C (with the busy input low), the raw interrupt vector is 0x01, the interrupt output is low and both DMA requests are low.
- R2: The status word has five bits. Bit0 follows the shifter busy input. Bit1 means the transmit queue is full, bit2 that it is empty, bit3 that the receive queue is empty and bit4 that it is full.
- R3: Each of the four level registers (address 0 transmit threshold, 1 receive threshold, 2 transmit DMA level, 3 receive DMA level) takes a written value only when it is below the queue depth. Otherwise it keeps its previous value.
- R4: Address 4 reads the transmit level and address 5 reads the receive level, each as the number of entries held. Both queues deliver words in the order they were accepted.
- R5: Raw interrupt bit0 is set while the transmit level is at or below the transmit threshold. Raw bit4 is set while the receive level is above the receive threshold.
- R6: A write to address 12 while the transmit queue is full is dropped, and it sets sticky raw bit1.
- R7: A read of address 12 while the receive queue is empty returns 0, removes nothing and sets sticky raw bit2.
- R8: A shifter push into a full receive queue is dropped, and it sets sticky raw bit3.
- R9: A write to the clear register (address 10) clears sticky flags. Bit0 clears all three, bit1 clears bit2 of the raw vector, bit2 clears raw bit3 and bit3 clears raw bit1. Flags not selected keep their value.
- R10: Address 7 holds the interrupt mask, address 8 reads the raw vector and address 9 reads raw AND mask. The interrupt output is the OR of the masked bits.
- R11: Address 11 bit0 enables the receive DMA request and bit1 enables the transmit DMA request. The transmit request is high while enabled and the transmit level is at or below the transmit DMA level. The receive request is high while enabled and the receive level is above the receive DMA level.
- R12: Address 6 reads the status word. Reads of addresses 10, 13, 14 and 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the data address removes a receive entry |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the addressed register |
| eng_busy | input | 1 | Shifter busy, shown in status bit0 |
| tx_pop | input | 1 | Shifter takes the transmit head |
| tx_data | output | DW | Transmit head word |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_data | input | DW | Received word |
| irq | output | 1 | Interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The embedded properties assume that the read and write strobes are never raised together for one address. They also assume that `tx_pop` and `rx_push` are single-cycle pulses whose data is valid in the cycle they are high. The bench drives every strobe for exactly one clock, changes inputs only on the falling edge, and pops the transmit queue only when its model says words are held. Overflow and underflow are reached on purpose: the bench writes one word past a full queue and reads one word from an empty queue.

// File: rtl/spi_fifo_pkg.sv
// Package: register addresses and vector bit positions shared by the FIFO
// status unit and its bench. Assumes a 4-bit register address space.
package spi_fifo_pkg;
    localparam logic [3:0] ADR_TX_THR  = 4'd0;
    localparam logic [3:0] ADR_RX_THR  = 4'd1;
    localparam logic [3:0] ADR_TX_DMAL = 4'd2;
    localparam logic [3:0] ADR_RX_DMAL = 4'd3;
    localparam logic [3:0] ADR_TX_LVL  = 4'd4;
    localparam logic [3:0] ADR_RX_LVL  = 4'd5;
    localparam logic [3:0] ADR_STATUS  = 4'd6;
    localparam logic [3:0] ADR_MASK    = 4'd7;
    localparam logic [3:0] ADR_RAW     = 4'd8;
    localparam logic [3:0] ADR_MASKED  = 4'd9;
    localparam logic [3:0] ADR_CLEAR   = 4'd10;
    localparam logic [3:0] ADR_DMA_EN  = 4'd11;
    localparam logic [3:0] ADR_DATA    = 4'd12;

    localparam int NUM_LIMITS = 4;
    localparam int VEC_W      = 5;

    // interrupt vector bit positions
    localparam int IV_TX_LOW  = 0;
    localparam int IV_TX_OVF  = 1;
    localparam int IV_RX_UDF  = 2;
    localparam int IV_RX_OVF  = 3;
    localparam int IV_RX_HIGH = 4;

    // clear word bit positions
    localparam int CL_ALL    = 0;
    localparam int CL_RX_UDF = 1;
    localparam int CL_RX_OVF = 2;
    localparam int CL_TX_OVF = 3;
endpackage

// File: rtl/spi_sync_queue.sv
// Module: synchronous circular queue with an occupancy count.
// Assumes push and pop arrive already qualified: never push when full,
// never pop when empty. The head word is shown combinationally.
module spi_sync_queue #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int LW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [LW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    // storage write; no reset needed on data
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // pointer and count update with explicit wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == LW'(DEPTH));
    assign empty = (count == '0);

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LW'(DEPTH));
    // R6
    push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R7
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/spi_limit_reg.sv
// Module: level register that accepts only values below the queue depth.
// Assumes the write strobe is already decoded for this register.
module spi_limit_reg #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [LW-1:0] value
);
    logic in_range;
    assign in_range = (32'(wdata) < DEPTH);

    // hold value; take a write only when it is in range
    always_ff @(posedge clk) begin
        if (!rst_n)               value <= '0;
        else if (we && in_range)  value <= wdata[LW-1:0];
    end

    // R3
    limit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !in_range) |=> $stable(value));
    // R3
    limit_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_range) |=> (32'(value) < DEPTH));
endmodule

// File: rtl/spi_irq_unit.sv
// Module: interrupt vector with sticky error flags, clear decode and mask.
// Assumes set pulses are single-cycle and the clear word is qualified by
// its write strobe. A set in the same cycle as its clear wins.
module spi_irq_unit
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_tx_ovf,
    input  logic             set_rx_udf,
    input  logic             set_rx_ovf,
    input  logic             clr_we,
    input  logic [3:0]       clr_word,
    input  logic             mask_we,
    input  logic [VEC_W-1:0] mask_wdata,
    input  logic [LW-1:0]    tx_lvl,
    input  logic [LW-1:0]    tx_thr,
    input  logic [LW-1:0]    rx_lvl,
    input  logic [LW-1:0]    rx_thr,
    output logic [VEC_W-1:0] mask,
    output logic [VEC_W-1:0] raw,
    output logic [VEC_W-1:0] masked,
    output logic             irq
);
    logic tx_ovf_q, rx_udf_q, rx_ovf_q;
    logic clr_txo, clr_rxu, clr_rxo;

    assign clr_txo = clr_we && (clr_word[CL_ALL] || clr_word[CL_TX_OVF]);
    assign clr_rxu = clr_we && (clr_word[CL_ALL] || clr_word[CL_RX_UDF]);
    assign clr_rxo = clr_we && (clr_word[CL_ALL] || clr_word[CL_RX_OVF]);

    // sticky error flags: set on event, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ovf_q <= 1'b0;
            rx_udf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
        end else begin
            tx_ovf_q <= set_tx_ovf || (tx_ovf_q && !clr_txo);
            rx_udf_q <= set_rx_udf || (rx_udf_q && !clr_rxu);
            rx_ovf_q <= set_rx_ovf || (rx_ovf_q && !clr_rxo);
        end
    end

    // mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wdata;
    end

    // raw vector assembly from levels and sticky flags
    always_comb begin
        raw             = '0;
        raw[IV_TX_LOW]  = (tx_lvl <= tx_thr);
        raw[IV_TX_OVF]  = tx_ovf_q;
        raw[IV_RX_UDF]  = rx_udf_q;
        raw[IV_RX_OVF]  = rx_ovf_q;
        raw[IV_RX_HIGH] = (rx_lvl > rx_thr);
    end

    assign masked = raw & mask;
    assign irq    = |masked;

    // R6
    txo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf_q && !clr_we) |=> tx_ovf_q);
    // R8
    rxo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf_q && !clr_we) |=> rx_ovf_q);
    // R9
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_word[CL_ALL] && !set_tx_ovf && !set_rx_udf && !set_rx_ovf)
        |=> (raw[IV_TX_OVF] == 1'b0 && raw[IV_RX_UDF] == 1'b0 && raw[IV_RX_OVF] == 1'b0));
    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
// Module: top of the SPI queue status unit. Owns both queues, the four
// level registers, the DMA enables, register decode and read mux.
// Assumes reg_wr and reg_rd are single-cycle strobes and DW >= LW, DW >= 5.
module spi_fifo_irq_ctrl
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [3:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          eng_busy,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_data,
    output logic          tx_avail,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_data,
    output logic          irq,
    output logic          tx_dma_req,
    output logic          rx_dma_req
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0]    limits [NUM_LIMITS];
    logic [LW-1:0]    tx_lvl, rx_lvl;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [DW-1:0]    rx_head;
    logic             data_wr, data_rd;
    logic             tx_push_ok, rx_pop_ok, tx_pop_ok, rx_push_ok;
    logic             tx_ovf_ev, rx_udf_ev, rx_ovf_ev;
    logic [1:0]       dma_en;
    logic [VEC_W-1:0] status, mask, raw, masked;

    // access qualification for the data register and the shifter ports
    assign data_wr    = reg_wr && (reg_addr == ADR_DATA);
    assign data_rd    = reg_rd && (reg_addr == ADR_DATA);
    assign tx_push_ok = data_wr && !tx_full;
    assign tx_ovf_ev  = data_wr && tx_full;
    assign rx_pop_ok  = data_rd && !rx_empty;
    assign rx_udf_ev  = data_rd && rx_empty;
    assign tx_pop_ok  = tx_pop && !tx_empty;
    assign rx_push_ok = rx_push && !rx_full;
    assign rx_ovf_ev  = rx_push && rx_full;

    // four range-limited level registers at addresses 0..3
    for (genvar g = 0; g < NUM_LIMITS; g++) begin : g_limit
        spi_limit_reg #(.DEPTH(DEPTH), .DW(DW)) u_limit (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (reg_wr && (reg_addr == 4'(g))),
            .wdata (reg_wdata),
            .value (limits[g])
        );
    end

    spi_sync_queue #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push_ok),
        .push_data (reg_wdata),
        .pop       (tx_pop_ok),
        .head      (tx_data),
        .count     (tx_lvl),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    spi_sync_queue #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_push_ok),
        .push_data (rx_data),
        .pop       (rx_pop_ok),
        .head      (rx_head),
        .count     (rx_lvl),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    spi_irq_unit #(.DEPTH(DEPTH)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_tx_ovf (tx_ovf_ev),
        .set_rx_udf (rx_udf_ev),
        .set_rx_ovf (rx_ovf_ev),
        .clr_we     (reg_wr && (reg_addr == ADR_CLEAR)),
        .clr_word   (reg_wdata[3:0]),
        .mask_we    (reg_wr && (reg_addr == ADR_MASK)),
        .mask_wdata (reg_wdata[VEC_W-1:0]),
        .tx_lvl     (tx_lvl),
        .tx_thr     (limits[0]),
        .rx_lvl     (rx_lvl),
        .rx_thr     (limits[1]),
        .mask       (mask),
        .raw        (raw),
        .masked     (masked),
        .irq        (irq)
    );

    // DMA enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                                   dma_en <= 2'b00;
        else if (reg_wr && (reg_addr == ADR_DMA_EN))  dma_en <= reg_wdata[1:0];
    end

    assign tx_avail   = !tx_empty;
    assign tx_dma_req = dma_en[1] && (tx_lvl <= limits[2]);
    assign rx_dma_req = dma_en[0] && (rx_lvl > limits[3]);
    assign status     = {rx_full, rx_empty, tx_empty, tx_full, eng_busy};

    // register read mux, zero-extended
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_TX_THR:  reg_rdata[LW-1:0]    = limits[0];
            ADR_RX_THR:  reg_rdata[LW-1:0]    = limits[1];
            ADR_TX_DMAL: reg_rdata[LW-1:0]    = limits[2];
            ADR_RX_DMAL: reg_rdata[LW-1:0]    = limits[3];
            ADR_TX_LVL:  reg_rdata[LW-1:0]    = tx_lvl;
            ADR_RX_LVL:  reg_rdata[LW-1:0]    = rx_lvl;
            ADR_STATUS:  reg_rdata[VEC_W-1:0] = status;
            ADR_MASK:    reg_rdata[VEC_W-1:0] = mask;
            ADR_RAW:     reg_rdata[VEC_W-1:0] = raw;
            ADR_MASKED:  reg_rdata[VEC_W-1:0] = masked;
            ADR_DMA_EN:  reg_rdata[1:0]       = dma_en;
            ADR_DATA:    reg_rdata            = rx_empty ? '0 : rx_head;
            default:     reg_rdata            = '0;
        endcase
    end

    // R7
    udf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_udf_ev |-> (reg_rdata == '0));
    // R6
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf_ev && !tx_pop) |=> (tx_lvl == LW'(DEPTH)));
    // R8
    rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf_ev && !data_rd) |=> raw[IV_RX_OVF]);
    // R11
    dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_en == 2'b00) |-> (!tx_dma_req && !rx_dma_req));
endmodule

// File: tb/spi_fifo_irq_ctrl_bench.sv
// Bench: scoreboard with queues of expected words; monitor processes compare
// transmit pops and data-register reads as the design produces them.
module spi_fifo_irq_ctrl_bench;
    import spi_fifo_pkg::*;

    localparam int DEPTH = 8;
    localparam int DW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          eng_busy = 1'b0;
    logic          tx_pop = 1'b0;
    logic [DW-1:0] tx_data;
    logic          tx_avail;
    logic          rx_push = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          irq, tx_dma_req, rx_dma_req;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] txq[$];
    logic [DW-1:0] rxq[$];

    always #10 clk = ~clk;

    spi_fifo_irq_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_spi_fifo_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .tx_pop(tx_pop), .tx_data(tx_data),
        .tx_avail(tx_avail), .rx_push(rx_push), .rx_data(rx_data),
        .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        if (a == ADR_DATA && txq.size() < DEPTH) txq.push_back(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #5 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic eng_pop(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tx_pop = 1'b1;
            @(negedge clk); tx_pop = 1'b0;
        end
    endtask

    task automatic eng_push(input logic [DW-1:0] d);
        @(negedge clk);
        rx_push = 1'b1; rx_data = d;
        if (rxq.size() < DEPTH) rxq.push_back(d);
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    // monitor: transmit head compared with the oldest expected word (R4)
    always @(posedge clk) begin
        if (rst_n && tx_pop) begin
            if (txq.size() == 0) chk("R4 pop with model empty", 32'(tx_avail), 32'd0);
            else chk("R4 tx order", 32'(tx_data), 32'(txq.pop_front()));
        end
    end

    // monitor: data-register reads compared with receive model (R4, R7)
    always @(posedge clk) begin
        if (rst_n && reg_rd && reg_addr == ADR_DATA) begin
            if (rxq.size() == 0) chk("R7 underflow data", 32'(reg_rdata), 32'd0);
            else chk("R4 rx order", 32'(reg_rdata), 32'(rxq.pop_front()));
        end
    end

    logic done = 1'b0;
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(ADR_TX_LVL, v); chk("R1 tx level", 32'(v), 0);
        rd(ADR_RX_LVL, v); chk("R1 rx level", 32'(v), 0);
        rd(ADR_STATUS, v); chk("R1 status", 32'(v), 32'h0C);
        rd(ADR_RAW, v);    chk("R1 raw", 32'(v), 32'h01);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 dma", 32'({tx_dma_req, rx_dma_req}), 0);

        // R2 busy input
        eng_busy = 1'b1;
        rd(ADR_STATUS, v); chk("R2 busy bit", 32'(v), 32'h0D);
        eng_busy = 1'b0;

        // R3 limits: in range taken, out of range kept, boundary
        wr(ADR_TX_THR, 5);         rd(ADR_TX_THR, v); chk("R3 tx thr 5", 32'(v), 5);
        wr(ADR_TX_THR, DEPTH);     rd(ADR_TX_THR, v); chk("R3 tx thr depth kept", 32'(v), 5);
        wr(ADR_TX_THR, DEPTH - 1); rd(ADR_TX_THR, v); chk("R3 tx thr max", 32'(v), DEPTH - 1);
        wr(ADR_TX_THR, 2);
        wr(ADR_RX_THR, 3);         wr(ADR_RX_THR, 16'h0109);
        rd(ADR_RX_THR, v); chk("R3 rx thr kept", 32'(v), 3);

        // R4/R5 partial transmit fill
        wr(ADR_DATA, 16'hA001); wr(ADR_DATA, 16'hA002); wr(ADR_DATA, 16'hA003);
        rd(ADR_TX_LVL, v); chk("R4 tx level 3", 32'(v), 3);
        rd(ADR_RAW, v);    chk("R5 tx above thr", 32'(v), 32'h00);
        rd(ADR_STATUS, v); chk("R2 tx partial", 32'(v), 32'h08);
        eng_pop(3);
        rd(ADR_TX_LVL, v); chk("R4 tx drained", 32'(v), 0);

        // R6 transmit overflow
        for (int i = 0; i < DEPTH; i++) wr(ADR_DATA, 16'hB000 + 16'(i));
        rd(ADR_STATUS, v); chk("R2 tx full", 32'(v), 32'h0A);
        wr(ADR_DATA, 16'hDEAD);
        rd(ADR_TX_LVL, v); chk("R6 level after drop", 32'(v), DEPTH);
        rd(ADR_RAW, v);    chk("R6 tx ovf sticky", 32'(v), 32'h02);
        eng_pop(DEPTH);

        // R5/R4 receive path
        for (int i = 0; i < 4; i++) eng_push(16'hC000 + 16'(i));
        rd(ADR_RX_LVL, v); chk("R4 rx level 4", 32'(v), 4);
        rd(ADR_RAW, v);    chk("R5 rx above thr", 32'(v), 32'h13);
        for (int i = 0; i < 4; i++) rd(ADR_DATA, v);
        rd(ADR_RX_LVL, v); chk("R4 rx drained", 32'(v), 0);

        // R7 underflow
        rd(ADR_DATA, v);   chk("R7 read empty", 32'(v), 0);
        rd(ADR_RAW, v);    chk("R7 udf sticky", 32'(v), 32'h07);

        // R8 receive overflow
        for (int i = 0; i <= DEPTH; i++) eng_push(16'hE000 + 16'(i));
        rd(ADR_STATUS, v); chk("R2 rx full", 32'(v), 32'h14);
        rd(ADR_RAW, v);    chk("R8 rx ovf sticky", 32'(v), 32'h1F);
        for (int i = 0; i < DEPTH; i++) rd(ADR_DATA, v);
        rd(ADR_RX_LVL, v); chk("R8 dropped word absent", 32'(v), 0);

        // R9 selective and global clear
        wr(ADR_CLEAR, 4'h2); rd(ADR_RAW, v); chk("R9 clear udf", 32'(v), 32'h0B);
        wr(ADR_CLEAR, 4'h8); rd(ADR_RAW, v); chk("R9 clear tx ovf", 32'(v), 32'h09);
        wr(ADR_CLEAR, 4'h1); rd(ADR_RAW, v); chk("R9 clear all", 32'(v), 32'h01);

        // R10 mask and interrupt
        chk("R10 masked off", 32'(irq), 0);
        wr(ADR_MASK, 5'h11);
        rd(ADR_MASKED, v); chk("R10 masked vector", 32'(v), 32'h01);
        chk("R10 irq on", 32'(irq), 1);
        rd(ADR_MASK, v);   chk("R10 mask readback", 32'(v), 32'h11);
        wr(ADR_MASK, 5'h10);
        chk("R10 irq off", 32'(irq), 0);

        // R11 DMA requests
        wr(ADR_TX_DMAL, 1); wr(ADR_RX_DMAL, 0);
        wr(ADR_DMA_EN, 2'b10);
        chk("R11 tx req low level", 32'({tx_dma_req, rx_dma_req}), 32'b10);
        wr(ADR_DATA, 16'h1111); wr(ADR_DATA, 16'h2222);
        chk("R11 tx req above level", 32'(tx_dma_req), 0);
        eng_pop(2);
        wr(ADR_DMA_EN, 2'b11);
        eng_push(16'h3333);
        chk("R11 rx req", 32'(rx_dma_req), 1);
        rd(ADR_DATA, v);
        chk("R11 rx req after read", 32'(rx_dma_req), 0);

        // R12 unused addresses read zero
        rd(4'd13, v); chk("R12 addr 13", 32'(v), 0);
        rd(ADR_CLEAR, v); chk("R12 clear reads zero", 32'(v), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule